// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

The engine draws into a linear, byte-addressed frame buffer. Software queues register writes into a small command FIFO. The engine consumes one queued write per cycle, but only while it is not drawing. Writing the size register launches an operation. A fill paints every element of a destination rectangle with a foreground colour. A copy moves a source rectangle onto a destination rectangle, and the two may overlap. Every element passes through a mix function, a per-bit write mask and an inclusive scissor window before it reaches memory.

The engine works one byte element at a time. A fill reads the destination and then writes it. A copy reads the source, then the destination, then writes. Software picks the starting corner of each operation. A direction bit for each axis says whether that axis steps up or down from the start. This is how an overlapping copy is made safe: on an axis where the destination lies at or before the source, start at the low edge and step up. Otherwise start at the high edge (start + size - 1) for both rectangles and step down.

A packed 24-bit mode handles three-byte pixels. Coordinates and widths are then given in bytes. The colour byte and the mask byte used for each element rotate through three lanes.

Top module: `blit_engine`

## Requirements
- R1: After reset, `busy` is 0, `fifo_free` equals FIFO_DEPTH, and neither `mem_rd` nor `mem_wr` is asserted.
- R2: A register write is accepted into the command FIFO when `fifo_free` is non-zero, and each accepted write lowers `fifo_free` by one. Entries are consumed only while no operation is running. A write made while `fifo_free` is 0 is discarded and has no effect on any register.
- R3: Writing register 2 (width in bits 31:16, height in bits 15:0) starts an operation. `busy` stays high until the last memory write of the operation has been made. If the width or the height is zero, no memory access is made.
- R4: Register 0 holds the destination start, with x in bits 31:16 and y in bits 15:0. Register 3 holds the pitch in bits 31:22 and the base in bits 19:0. Element (x,y) is at byte address base*8 + y*pitch*8 + x.
- R5: Bit 0 of register 4 set makes x step +1 from the start column; clear makes it step -1. Bit 1 does the same for y. A whole row is finished before the next row begins.
- R6: Register 5 bit 0 selects the source: 0 means a fill with the foreground colour in register 7, and 1 means a copy from the start point in register 1 (same packing as register 0). The source steps in the same directions as the destination. An overlapping copy whose start corner follows the per-axis rule leaves the destination equal to the original source.
- R7: Register 6 bits 3:0 select the mix. Code 7 passes the source through, code 5 writes source XOR destination, and every other code behaves as code 7.
- R8: Register 8 is a write mask. Where a mask bit is 1 the element bit takes the mixed value; where it is 0 the bit keeps its old value. Outside 24-bit mode, mask bits 7:0 and colour bits 7:0 are used.
- R9: Register 9 holds the left bound in bits 12:0 and the right bound in bits 28:16. Register 10 holds the top bound in 12:0 and the bottom bound in 28:16. The bounds are inclusive. An element outside them gets no memory access and keeps its contents.
- R10: When register 4 bit 7 is set, each element uses colour byte lane L and mask byte lane L, where L = (x + rot) mod 3 and rot is register 4 bits 10:8. Lane L is bits 8L+7:8L.
- R11: When a write is accepted in the same cycle that the engine consumes an entry, `fifo_free` is unchanged.
- R12: The engine never reads and writes in the same cycle. Every write goes to the address that was read in the cycle just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | FIFO not empty or operation in progress |
| fifo_free | output | $clog2(FIFO_DEPTH+1) | Free command FIFO entries |
| mem_rd | output | 1 | Frame buffer read request |
| mem_wr | output | 1 | Frame buffer write request |
| mem_addr | output | ADDR_W | Frame buffer byte address |
| mem_wdata | output | 8 | Frame buffer write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |

## Verification
Two things can happen in the same cycle: a new register write entering the command FIFO, and the idle engine removing the oldest entry. The bench provokes this by streaming non-starting register writes on consecutive cycles into an idle engine. After each clock edge, `fifo_free` must sit at one below the depth during the stream, and it must return to the full depth one cycle after the stream ends. A second scenario keeps the engine busy with a long fill so that nothing is consumed. The FIFO then fills to zero free entries, a further write is dropped, and that drop is confirmed later through the colour of a follow-up fill.

// File: rtl/blit_pkg.sv
`timescale 1ns/1ps
package blit_pkg;

    localparam logic [3:0] RA_DST   = 4'd0;
    localparam logic [3:0] RA_SRC   = 4'd1;
    localparam logic [3:0] RA_SIZE  = 4'd2;
    localparam logic [3:0] RA_PITCH = 4'd3;
    localparam logic [3:0] RA_CTL   = 4'd4;
    localparam logic [3:0] RA_SEL   = 4'd5;
    localparam logic [3:0] RA_MIX   = 4'd6;
    localparam logic [3:0] RA_FG    = 4'd7;
    localparam logic [3:0] RA_MASK  = 4'd8;
    localparam logic [3:0] RA_CLIPX = 4'd9;
    localparam logic [3:0] RA_CLIPY = 4'd10;

    localparam logic [3:0] MIX_SRC = 4'h7;
    localparam logic [3:0] MIX_XOR = 4'h5;

    typedef struct packed {
        logic [3:0]  addr;
        logic [31:0] data;
    } cmd_t;

    typedef struct packed {
        logic [15:0] dst_x;
        logic [15:0] dst_y;
        logic [15:0] src_x;
        logic [15:0] src_y;
        logic [15:0] width;
        logic [15:0] height;
        logic [9:0]  pitch;
        logic [19:0] offset;
        logic        dir_x;
        logic        dir_y;
        logic        pack24;
        logic [2:0]  rot;
        logic        copy;
        logic [3:0]  mix;
        logic [31:0] fg;
        logic [31:0] mask;
        logic [12:0] clip_l;
        logic [12:0] clip_r;
        logic [12:0] clip_t;
        logic [12:0] clip_b;
    } cfg_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ELEM,
        S_SRCW,
        S_DSTW
    } walk_st_e;

endpackage

// File: rtl/blit_cmd_fifo.sv
`timescale 1ns/1ps
module blit_cmd_fifo
    import blit_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  cmd_t          push_data,
    input  logic          pop,
    output cmd_t          pop_data,
    output logic          empty,
    output logic [CW-1:0] free
);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    cmd_t     slots [DEPTH];
    logic     accept;
    logic     take;

    always_comb begin
        d      = q;
        accept = push && (q.cnt != CW'(DEPTH));
        take   = pop && (q.cnt != '0);
        if (accept) begin
            d.wp = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (take) begin
            d.rp = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        case ({accept, take})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            slots[q.wp] <= push_data;
        end
    end

    assign pop_data = slots[q.rp];
    assign empty    = (q.cnt == '0);
    assign free     = CW'(DEPTH) - q.cnt;

endmodule

// File: rtl/blit_regs.sv
`timescale 1ns/1ps
module blit_regs
    import blit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_vld,
    input  cmd_t cmd,
    output cfg_t cfg,
    output logic start
);

    typedef struct packed {
        cfg_t cfg;
        logic start;
    } regs_st_t;

    regs_st_t q, d;

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c        = '0;
        c.dir_x  = 1'b1;
        c.dir_y  = 1'b1;
        c.mix    = MIX_SRC;
        c.mask   = '1;
        c.clip_r = '1;
        c.clip_b = '1;
        return c;
    endfunction

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (cmd_vld) begin
            case (cmd.addr)
                RA_DST: begin
                    d.cfg.dst_x = cmd.data[31:16];
                    d.cfg.dst_y = cmd.data[15:0];
                end
                RA_SRC: begin
                    d.cfg.src_x = cmd.data[31:16];
                    d.cfg.src_y = cmd.data[15:0];
                end
                RA_SIZE: begin
                    d.cfg.width  = cmd.data[31:16];
                    d.cfg.height = cmd.data[15:0];
                    d.start      = 1'b1;
                end
                RA_PITCH: begin
                    d.cfg.pitch  = cmd.data[31:22];
                    d.cfg.offset = cmd.data[19:0];
                end
                RA_CTL: begin
                    d.cfg.dir_x  = cmd.data[0];
                    d.cfg.dir_y  = cmd.data[1];
                    d.cfg.pack24 = cmd.data[7];
                    d.cfg.rot    = cmd.data[10:8];
                end
                RA_SEL:   d.cfg.copy = cmd.data[0];
                RA_MIX:   d.cfg.mix  = cmd.data[3:0];
                RA_FG:    d.cfg.fg   = cmd.data;
                RA_MASK:  d.cfg.mask = cmd.data;
                RA_CLIPX: begin
                    d.cfg.clip_l = cmd.data[12:0];
                    d.cfg.clip_r = cmd.data[28:16];
                end
                RA_CLIPY: begin
                    d.cfg.clip_t = cmd.data[12:0];
                    d.cfg.clip_b = cmd.data[28:16];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cfg   <= cfg_reset();
            q.start <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cfg   = q.cfg;
    assign start = q.start;

endmodule

// File: rtl/blit_walker.sv
`timescale 1ns/1ps
module blit_walker
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cfg_t              cfg,
    output logic              active,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    typedef struct packed {
        walk_st_e    st;
        logic [15:0] x;
        logic [15:0] y;
        logic [15:0] sx;
        logic [15:0] sy;
        logic [15:0] col;
        logic [15:0] row;
        logic [7:0]  src_byte;
    } walk_t;

    walk_t q, d;

    function automatic logic [ADDR_W-1:0] lin_addr(
        input logic [15:0] px,
        input logic [15:0] py,
        input logic [9:0]  pitch,
        input logic [19:0] base
    );
        logic [31:0] a;
        a = {9'd0, base, 3'd0} + ((32'(py) * 32'(pitch)) << 3) + 32'(px);
        return a[ADDR_W-1:0];
    endfunction

    logic [ADDR_W-1:0] dst_addr;
    logic [ADDR_W-1:0] src_addr;
    logic              clipped;
    logic [16:0]       lane_sum;
    logic [1:0]        lane;
    logic [7:0]        fg_b;
    logic [7:0]        msk_b;
    logic [7:0]        src_v;
    logic [7:0]        mixed;
    logic              advance;
    logic              last_col;
    logic              last_row;

    always_comb begin
        dst_addr = lin_addr(q.x, q.y, cfg.pitch, cfg.offset);
        src_addr = lin_addr(q.sx, q.sy, cfg.pitch, cfg.offset);
        clipped  = (q.x < {3'd0, cfg.clip_l}) || (q.x > {3'd0, cfg.clip_r}) ||
                   (q.y < {3'd0, cfg.clip_t}) || (q.y > {3'd0, cfg.clip_b});
        lane_sum = {1'b0, q.x} + 17'(cfg.rot);
        lane     = 2'(lane_sum % 17'd3);
        fg_b     = cfg.pack24 ? cfg.fg[{lane, 3'b000} +: 8]   : cfg.fg[7:0];
        msk_b    = cfg.pack24 ? cfg.mask[{lane, 3'b000} +: 8] : cfg.mask[7:0];
        src_v    = cfg.copy ? q.src_byte : fg_b;
        mixed    = (cfg.mix == MIX_XOR) ? (src_v ^ mem_rdata) : src_v;
        last_col = (q.col == cfg.width - 16'd1);
        last_row = (q.row == cfg.height - 16'd1);
    end

    always_comb begin
        d         = q;
        advance   = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = dst_addr;
        mem_wdata = '0;
        case (q.st)
            S_IDLE: begin
                if (start && (cfg.width != '0) && (cfg.height != '0)) begin
                    d.st  = S_ELEM;
                    d.x   = cfg.dst_x;
                    d.y   = cfg.dst_y;
                    d.sx  = cfg.src_x;
                    d.sy  = cfg.src_y;
                    d.col = '0;
                    d.row = '0;
                end
            end
            S_ELEM: begin
                if (clipped) begin
                    advance = 1'b1;
                end else if (cfg.copy) begin
                    mem_rd   = 1'b1;
                    mem_addr = src_addr;
                    d.st     = S_SRCW;
                end else begin
                    mem_rd = 1'b1;
                    d.st   = S_DSTW;
                end
            end
            S_SRCW: begin
                mem_rd     = 1'b1;
                d.src_byte = mem_rdata;
                d.st       = S_DSTW;
            end
            S_DSTW: begin
                mem_wr    = 1'b1;
                mem_wdata = (mixed & msk_b) | (mem_rdata & ~msk_b);
                advance   = 1'b1;
            end
            default: d.st = S_IDLE;
        endcase

        if (advance) begin
            if (last_col) begin
                if (last_row) begin
                    d.st = S_IDLE;
                end else begin
                    d.st  = S_ELEM;
                    d.col = '0;
                    d.row = q.row + 16'd1;
                    d.x   = cfg.dst_x;
                    d.sx  = cfg.src_x;
                    d.y   = cfg.dir_y ? q.y + 16'd1 : q.y - 16'd1;
                    d.sy  = cfg.dir_y ? q.sy + 16'd1 : q.sy - 16'd1;
                end
            end else begin
                d.st  = S_ELEM;
                d.col = q.col + 16'd1;
                d.x   = cfg.dir_x ? q.x + 16'd1 : q.x - 16'd1;
                d.sx  = cfg.dir_x ? q.sx + 16'd1 : q.sx - 16'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign active = (q.st != S_IDLE);

endmodule

// File: rtl/blit_engine.sv
`timescale 1ns/1ps
module blit_engine
    import blit_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int FIFO_DEPTH = 8,
    localparam int FREE_W    = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              busy,
    output logic [FREE_W-1:0] fifo_free,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    cmd_t wr_cmd;
    cmd_t head_cmd;
    cfg_t cfg;
    logic fifo_empty;
    logic pop;
    logic start;
    logic walking;

    assign wr_cmd = '{addr: reg_addr, data: reg_wdata};
    assign pop    = !fifo_empty && !walking && !start;
    assign busy   = walking || start || !fifo_empty;

    blit_cmd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (reg_wr),
        .push_data (wr_cmd),
        .pop       (pop),
        .pop_data  (head_cmd),
        .empty     (fifo_empty),
        .free      (fifo_free)
    );

    blit_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_vld (pop),
        .cmd     (head_cmd),
        .cfg     (cfg),
        .start   (start)
    );

    blit_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg       (cfg),
        .active    (walking),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: rtl/blit_engine_sva.sv
`timescale 1ns/1ps
module blit_engine_sva #(
    parameter int ADDR_W     = 24,
    parameter int FIFO_DEPTH = 8,
    localparam int FREE_W    = $clog2(FIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              busy,
    input logic [FREE_W-1:0] fifo_free,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr
);

    // R3: memory is touched only while an operation is in flight
    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    // R12: read and write never share a cycle
    a_r12_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R12: write lands on the address read one cycle earlier
    a_r12_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd) && ($past(mem_addr) == mem_addr)));

    // R2: free count never exceeds depth
    a_r2_free_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_free) <= FIFO_DEPTH);

    // R2: an accepted write makes the block busy
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (fifo_free != '0)) |=> busy);

    // R2: a full FIFO takes nothing, so free grows by at most one
    a_r2_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_free == '0) |=> (int'(fifo_free) <= 1));

    // R11: free count moves by at most one per cycle
    a_r11_free_step: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fifo_free) == int'($past(fifo_free))) ||
        (int'(fifo_free) == int'($past(fifo_free)) + 1) ||
        (int'(fifo_free) + 1 == int'($past(fifo_free))));

endmodule

bind blit_engine blit_engine_sva #(
    .ADDR_W     (ADDR_W),
    .FIFO_DEPTH (FIFO_DEPTH)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .busy      (busy),
    .fifo_free (fifo_free),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr)
);

// File: tb/blit_engine_tb_top.sv
`timescale 1ns/1ps
module blit_engine_tb_top;
    import blit_pkg::*;

    localparam int AW    = 12;
    localparam int DEPTH = 4;
    localparam int FW    = $clog2(DEPTH + 1);
    localparam int MEMSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          busy;
    logic [FW-1:0] fifo_free;
    logic          mem_rd;
    logic          mem_wr;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;

    always #10 clk = ~clk;

    blit_engine #(.ADDR_W(AW), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .fifo_free(fifo_free),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [7:0] ram [MEMSZ];
    logic [7:0] mdl [MEMSZ];

    always @(posedge clk) begin
        if (mem_wr) ram[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= ram[mem_addr];
    end

    typedef struct {
        logic [AW-1:0] a;
        logic [7:0]    d;
        string         tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    function automatic void check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endfunction

    // model configuration
    int          g_pitch = 8;
    int          g_off   = 0;
    logic [31:0] g_fg    = '0;
    logic [31:0] g_mask  = '1;
    logic [3:0]  g_mix   = 4'h7;
    bit          g_copy  = 0;
    bit          g_dirx  = 1;
    bit          g_diry  = 1;
    bit          g_p24   = 0;
    int          g_rot   = 0;
    int          g_cl = 0, g_cr = 8191, g_ct = 0, g_cb = 8191;

    function automatic int fb_addr(int x, int y);
        return (g_off * 8 + y * g_pitch * 8 + x) & (MEMSZ - 1);
    endfunction

    // scoreboard monitor, sampled away from the active edge
    logic          prev_rd = 0;
    logic [AW-1:0] prev_a  = '0;
    always @(negedge clk) begin
        if (rst_n && mem_wr) begin
            check(prev_rd && (prev_a == mem_addr), "R12", "write not preceded by read of same address",
                  longint'(prev_a), longint'(mem_addr));
            if (sbq.size() == 0) begin
                check(0, "R3", "unexpected write address", longint'(mem_addr), 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(mem_addr == e.a, e.tag, "write address", longint'(mem_addr), longint'(e.a));
                check(mem_wdata == e.d, e.tag, "write data", longint'(mem_wdata), longint'(e.d));
            end
        end
        prev_rd <= mem_rd;
        prev_a  <= mem_addr;
    end

    task automatic reg_write(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(!busy, tag, "engine still busy", longint'(busy), 0);
        check(sbq.size() == 0, tag, "writes missing when busy fell", sbq.size(), 0);
    endtask

    task automatic op(input int dx, input int dy, input int sx, input int sy,
                      input int w, input int h, input string tag,
                      input bit wr_fg = 1, input bit do_wait = 1);
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                int x, y, px, py, lane, da;
                logic [7:0] s, dv, m, v, nv;
                exp_t e;
                x  = g_dirx ? dx + c : dx - c;
                y  = g_diry ? dy + r : dy - r;
                px = g_dirx ? sx + c : sx - c;
                py = g_diry ? sy + r : sy - r;
                if (x < g_cl || x > g_cr || y < g_ct || y > g_cb) continue;
                lane = g_p24 ? (x + g_rot) % 3 : 0;
                da = fb_addr(x, y);
                s  = g_copy ? mdl[fb_addr(px, py)] : g_fg[lane*8 +: 8];
                dv = mdl[da];
                m  = g_mask[lane*8 +: 8];
                v  = (g_mix == 4'h5) ? (s ^ dv) : s;
                nv = (v & m) | (dv & ~m);
                mdl[da] = nv;
                e.a = AW'(da); e.d = nv; e.tag = tag;
                sbq.push_back(e);
            end
        end
        reg_write(RA_DST,   {16'(dx), 16'(dy)});
        reg_write(RA_SRC,   {16'(sx), 16'(sy)});
        reg_write(RA_PITCH, (32'(g_pitch) << 22) | 32'(g_off));
        reg_write(RA_CTL,   {21'd0, 3'(g_rot), g_p24, 5'd0, g_diry, g_dirx});
        reg_write(RA_SEL,   {31'd0, g_copy});
        reg_write(RA_MIX,   {28'd0, g_mix});
        if (wr_fg) reg_write(RA_FG, g_fg);
        reg_write(RA_MASK,  g_mask);
        reg_write(RA_CLIPX, {3'd0, 13'(g_cr), 3'd0, 13'(g_cl)});
        reg_write(RA_CLIPY, {3'd0, 13'(g_cb), 3'd0, 13'(g_ct)});
        reg_write(RA_SIZE,  {16'(w), 16'(h)});
        if (do_wait) wait_idle(tag);
    endtask

    task automatic set_plain();
        g_copy = 0; g_mix = 4'h7; g_mask = '1; g_p24 = 0; g_rot = 0;
        g_dirx = 1; g_diry = 1; g_cl = 0; g_cr = 8191; g_ct = 0; g_cb = 8191;
    endtask

    task automatic copy_test(input int sx0, input int sy0, input int dx0, input int dy0,
                             input int w, input int h);
        logic [7:0] snap [256];
        int dx, dy, sx, sy;
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                snap[r*w + c] = mdl[fb_addr(sx0 + c, sy0 + r)];
        set_plain();
        g_copy = 1;
        g_dirx = (dx0 <= sx0);
        g_diry = (dy0 <= sy0);
        dx = g_dirx ? dx0 : dx0 + w - 1;
        sx = g_dirx ? sx0 : sx0 + w - 1;
        dy = g_diry ? dy0 : dy0 + h - 1;
        sy = g_diry ? sy0 : sy0 + h - 1;
        op(dx, dy, sx, sy, w, h, "R6");
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                check(ram[fb_addr(dx0 + c, dy0 + r)] == snap[r*w + c], "R6",
                      "overlapped copy result", longint'(ram[fb_addr(dx0 + c, dy0 + r)]),
                      longint'(snap[r*w + c]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < MEMSZ; a++) begin
            ram[a] = 8'(a * 37 + 5);
            mdl[a] = 8'(a * 37 + 5);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(busy == 0, "R1", "busy after reset", longint'(busy), 0);
        check(fifo_free == FW'(DEPTH), "R1", "free after reset", longint'(fifo_free), DEPTH);
        check(!mem_rd && !mem_wr, "R1", "memory strobes after reset", longint'({mem_rd, mem_wr}), 0);

        // R4 basic fill, R5 all four walk directions
        set_plain();
        g_fg = 32'h0000_00C3;
        op(2, 3, 0, 0, 5, 4, "R4");
        g_fg = 32'h0000_0011; g_dirx = 0; g_diry = 1; op(30, 2, 0, 0, 4, 3, "R5");
        g_fg = 32'h0000_0022; g_dirx = 1; g_diry = 0; op(40, 6, 0, 0, 4, 3, "R5");
        g_fg = 32'h0000_0033; g_dirx = 0; g_diry = 0; op(50, 6, 0, 0, 4, 3, "R5");
        // R4 non-zero base
        set_plain(); g_off = 16; g_fg = 32'h0000_0077;
        op(1, 1, 0, 0, 3, 2, "R4");
        g_off = 0;

        // R6 overlapping copies, four corner choices
        copy_test(10, 10, 13, 12, 8, 6);
        copy_test(10, 20, 7, 18, 8, 6);
        copy_test(10, 30, 13, 28, 8, 6);
        copy_test(30, 30, 27, 32, 8, 6);

        // R7 mix codes
        set_plain(); g_mix = 4'h5; g_fg = 32'h0000_00FF; op(4, 40, 0, 0, 6, 2, "R7");
        set_plain(); g_mix = 4'h3; g_fg = 32'h0000_0042; op(4, 43, 0, 0, 6, 2, "R7");
        set_plain(); g_mix = 4'h5; g_copy = 1; op(20, 40, 20, 44, 5, 2, "R7");

        // R8 write mask
        set_plain(); g_mask = 32'h0000_000F; g_fg = 32'h0000_00A5; op(12, 46, 0, 0, 7, 3, "R8");

        // R9 scissor window
        set_plain(); g_fg = 32'h0000_005C; g_cl = 22; g_cr = 25; g_ct = 51; g_cb = 54;
        op(20, 50, 0, 0, 10, 8, "R9");
        for (int y = 50; y < 58; y++)
            for (int x = 20; x < 30; x++)
                check(ram[fb_addr(x, y)] == mdl[fb_addr(x, y)], "R9", "scissor region content",
                      longint'(ram[fb_addr(x, y)]), longint'(mdl[fb_addr(x, y)]));

        // R10 packed 24-bit lanes
        set_plain(); g_p24 = 1; g_rot = 2; g_fg = 32'h0011_2233; op(30, 46, 0, 0, 9, 2, "R10");
        set_plain(); g_p24 = 1; g_rot = 4; g_fg = 32'h00AB_CDEF; g_mask = 32'h0000_FF00;
        op(33, 49, 0, 0, 9, 2, "R10");

        // R3 zero size: no access
        set_plain(); g_fg = 32'h0000_0099;
        op(5, 5, 0, 0, 0, 3, "R3");
        op(5, 5, 0, 0, 3, 0, "R3");

        // R11 push and pop in the same cycle
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            reg_wr = 1'b1; reg_addr = RA_MIX; reg_wdata = 32'h7;
            @(negedge clk);
            check(fifo_free == FW'(DEPTH - 1), "R11", "free during stream", longint'(fifo_free), DEPTH - 1);
        end
        reg_wr = 1'b0;
        @(negedge clk);
        check(fifo_free == FW'(DEPTH), "R11", "free after stream", longint'(fifo_free), DEPTH);

        // R2 queue while busy, drop when full
        set_plain(); g_fg = 32'h0000_0003;
        op(0, 0, 0, 0, 40, 40, "R2", 1, 0);
        check(busy == 1, "R2", "busy during long fill", longint'(busy), 1);
        reg_write(RA_FG, 32'h0000_005A);
        check(fifo_free == FW'(DEPTH - 1), "R2", "free after one queued", longint'(fifo_free), DEPTH - 1);
        for (int k = 1; k < DEPTH; k++) reg_write(RA_FG, 32'h0000_005A);
        check(fifo_free == 0, "R2", "free when full", longint'(fifo_free), 0);
        reg_write(RA_FG, 32'h0000_00EE);
        check(fifo_free == 0, "R2", "free after dropped write", longint'(fifo_free), 0);
        wait_idle("R2");
        check(fifo_free == FW'(DEPTH), "R2", "free after drain", longint'(fifo_free), DEPTH);
        g_fg = 32'h0000_005A;
        op(44, 58, 0, 0, 4, 2, "R2", 0, 1);

        // whole frame buffer against model
        begin
            int diffs = 0;
            for (int a = 0; a < MEMSZ; a++) if (ram[a] !== mdl[a]) diffs++;
            check(diffs == 0, "R4", "frame buffer differences", diffs, 0);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule